// File: doc/BRIEF.md
# Banked Level Interrupt Collector

This block collects a set of level-sensitive interrupt requests from board peripherals and presents them to a host processor as a single active-low level request line. The sources are grouped into 16-bit banks. Each bank has a read-only status word that shows which sources are asserted, and a read/write mask word whose set bits block the matching sources. The host reaches all of these words through a simple synchronous 16-bit register bus with one strobe and one write flag.

Every source input first passes through a two-flop synchronizer. One source position can be declared active-low by parameter, and it is inverted before it reaches its status bit. A source counts as effectively pending when its status bit is set and its mask bit is clear. The host line is driven low while at least one source is effectively pending. After reset every mask bit is set, so the host sees no request until software clears mask bits.

Top module: `irq_collector`

## Requirements
- R1: While reset is held, and in the first cycle after it, both mask words read 0xFFFF, `irq_n_o` is high and `bus_rdata` is 0.
- R2: Status word at offset 0x20 shows sources 0..15 (bit n = source n). Status word at offset 0x22 shows sources 16..31 (bit n = source 16+n). A change on a source input shows in status on the second rising clock edge after the input changes.
- R3: Mask words at offset 0x30 (sources 0..15) and 0x32 (sources 16..31) take the full 16-bit write data on a write strobe and read back the value written.
- R4: `irq_n_o` is low exactly when some source has its status bit at 1 and its mask bit at 0. A mask write changes `irq_n_o` in the cycle right after the write edge.
- R5: A status bit stays at 1 for as long as its source input is held, and it returns to 0 two edges after the input is released.
- R6: Source 15 is active-low: `src_i[15]` = 0 sets status bit 15 of the word at 0x20, and `src_i[15]` = 1 clears it. All other sources are active-high.
- R7: Writes to the status offsets 0x20 and 0x22 change no state. Reads of any offset other than 0x20, 0x22, 0x30 and 0x32 return 0.
- R8: Read data is registered. It appears on `bus_rdata` after the rising edge that samples a read strobe (`bus_sel`=1, `bus_wr`=0), and it holds until the next read.
- R9: With 0xFFFF written to both mask words, `irq_n_o` stays high even when all 32 sources are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt source levels; bit 15 active-low, others active-high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | 16 | Byte offset of the accessed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_n_o | output | 1 | Combined host request, low while any unmasked source is pending |

## Verification
The hardest case to reach is the inverted source position. Its idle level is high, so a bench that drives every input low by default pends it by accident and hides a missing inversion. The stimulus keeps that input high as its idle value. It then drives it low on its own with only that mask bit cleared, and again inside an all-sources-pending pattern where the full mask must still hold the line high. Release timing is checked by sampling the request line one and two edges after a source drops.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Result of decoding one bus offset against the banked register layout
   typedef struct packed {
      logic       is_stat;
      logic       is_mask;
      logic [3:0] bank;
   } reg_hit_t;

   localparam int MAX_BANKS = 16;

   function automatic reg_hit_t decode_offset(
      input logic [31:0] addr,
      input logic [31:0] stat_base,
      input logic [31:0] mask_base,
      input logic [31:0] stride,
      input int          n_banks
   );
      reg_hit_t hit;
      hit = '0;
      for (int b = 0; b < MAX_BANKS; b++) begin
         if (b < n_banks) begin
            if (addr == stat_base + stride * 32'(b)) begin
               hit.is_stat = 1'b1;
               hit.bank    = 4'(b);
            end
            if (addr == mask_base + stride * 32'(b)) begin
               hit.is_mask = 1'b1;
               hit.bank    = 4'(b);
            end
         end
      end
      return hit;
   endfunction

endpackage

// File: rtl/irqc_sync.sv
// Per-source polarity normalisation followed by a multi-flop synchronizer.
module irqc_sync #(
   parameter int              WIDTH    = 32,
   parameter int              STAGES   = 2,
   parameter logic [WIDTH-1:0] INV_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqc_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic             lvl;
      logic [STAGES-1:0] chain;

      if (INV_MASK[i]) begin : g_inv
         assign lvl = ~din[i];
      end else begin : g_pass
         assign lvl = din[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], lvl};
      end

      assign dout[i] = chain[STAGES-1];
   end
endmodule

// File: rtl/irqc_regs.sv
// Mask words, one per bank, written through the decoded register bus.
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int                        BANK_W    = 16,
   parameter int                        NUM_BANKS = 2,
   parameter logic [BANK_W*NUM_BANKS-1:0] MASK_RST = '1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_stb,
   input  reg_hit_t                    hit,
   input  logic [BANK_W-1:0]           wdata,
   output logic [BANK_W*NUM_BANKS-1:0] mask_o
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic wr_here;
      assign wr_here = wr_stb && hit.is_mask && (hit.bank == 4'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mask_o[b*BANK_W +: BANK_W] <= MASK_RST[b*BANK_W +: BANK_W];
         else if (wr_here) mask_o[b*BANK_W +: BANK_W] <= wdata;
      end
   end
endmodule

// File: rtl/irqc_rdpath.sv
// Registered read-back multiplexer over status and mask banks.
module irqc_rdpath
   import irqc_pkg::*;
#(
   parameter int BANK_W    = 16,
   parameter int NUM_BANKS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_stb,
   input  reg_hit_t                    hit,
   input  logic [BANK_W*NUM_BANKS-1:0] stat,
   input  logic [BANK_W*NUM_BANKS-1:0] mask,
   output logic [BANK_W-1:0]           rdata
);
   logic [BANK_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (hit.bank == 4'(b)) begin
            if (hit.is_stat) rd_next = stat[b*BANK_W +: BANK_W];
            if (hit.is_mask) rd_next = mask[b*BANK_W +: BANK_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_stb) rdata <= rd_next;
   end
endmodule

// File: rtl/irqc_merge.sv
// Effective-pending reduction and output polarity.
module irqc_merge #(
   parameter int   WIDTH      = 32,
   parameter bit   OUT_ACT_LOW = 1'b1
) (
   input  logic [WIDTH-1:0] stat,
   input  logic [WIDTH-1:0] mask,
   output logic             irq_o
);
   logic [WIDTH-1:0] eff;
   logic             any_pend;

   assign eff      = stat & ~mask;
   assign any_pend = |eff;

   if (OUT_ACT_LOW) begin : g_low
      assign irq_o = ~any_pend;
   end else begin : g_high
      assign irq_o = any_pend;
   end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
   import irqc_pkg::*;
#(
   parameter int                 NUM_SRC     = 32,
   parameter int                 BANK_W      = 16,
   parameter int                 ADDR_W      = 16,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0]  STAT_BASE   = 16'h0020,
   parameter logic [ADDR_W-1:0]  MASK_BASE   = 16'h0030,
   parameter logic [ADDR_W-1:0]  BANK_STRIDE = 16'h0002,
   parameter logic [NUM_SRC-1:0] SRC_ACT_LOW = 32'h0000_8000,
   parameter bit                 OUT_ACT_LOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BANK_W-1:0]  bus_wdata,
   output logic [BANK_W-1:0]  bus_rdata,
   output logic               irq_n_o
);
   localparam int NUM_BANKS = NUM_SRC / BANK_W;

   if (NUM_BANKS * BANK_W != NUM_SRC) begin : g_bad_split
      $error("irq_collector: NUM_SRC must be a multiple of BANK_W");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("irq_collector: bank count out of range");
   end
   if (ADDR_W > 32) begin : g_bad_addr
      $error("irq_collector: ADDR_W above 32 not supported");
   end

   logic [NUM_SRC-1:0] stat_q;
   logic [NUM_SRC-1:0] mask_q;
   reg_hit_t           hit;
   logic               wr_stb;
   logic               rd_stb;

   assign hit    = decode_offset(32'(bus_addr), 32'(STAT_BASE), 32'(MASK_BASE),
                                 32'(BANK_STRIDE), NUM_BANKS);
   assign wr_stb = bus_sel &&  bus_wr;
   assign rd_stb = bus_sel && !bus_wr;

   irqc_sync #(
      .WIDTH   (NUM_SRC),
      .STAGES  (SYNC_STAGES),
      .INV_MASK(SRC_ACT_LOW)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (src_i),
      .dout (stat_q)
   );

   irqc_regs #(
      .BANK_W   (BANK_W),
      .NUM_BANKS(NUM_BANKS),
      .MASK_RST ({NUM_SRC{1'b1}})
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_stb(wr_stb),
      .hit   (hit),
      .wdata (bus_wdata),
      .mask_o(mask_q)
   );

   irqc_rdpath #(
      .BANK_W   (BANK_W),
      .NUM_BANKS(NUM_BANKS)
   ) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_stb(rd_stb),
      .hit   (hit),
      .stat  (stat_q),
      .mask  (mask_q),
      .rdata (bus_rdata)
   );

   irqc_merge #(
      .WIDTH      (NUM_SRC),
      .OUT_ACT_LOW(OUT_ACT_LOW)
   ) u_merge (
      .stat (stat_q),
      .mask (mask_q),
      .irq_o(irq_n_o)
   );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int                 NUM_SRC     = 32,
   parameter int                 BANK_W      = 16,
   parameter int                 ADDR_W      = 16,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0]  STAT_BASE   = 16'h0020,
   parameter logic [ADDR_W-1:0]  MASK_BASE   = 16'h0030,
   parameter logic [NUM_SRC-1:0] SRC_ACT_LOW = 32'h0000_8000
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [BANK_W-1:0]  bus_wdata,
   input logic [BANK_W-1:0]  bus_rdata,
   input logic               irq_n_o,
   input logic [NUM_SRC-1:0] stat_q,
   input logic [NUM_SRC-1:0] mask_q
);
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R1: reset leaves all sources masked and the line idle
   p_mask_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (mask_q == '1) && irq_n_o && (bus_rdata == '0));

   // R2: status follows normalised sources after the synchronizer
   if (SYNC_STAGES == 2) begin : g_lat
      p_sync_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc >= 2'd2) |-> (stat_q == $past(src_i ^ SRC_ACT_LOW, 2)));
   end

   // R3: write to the low mask word lands on the next edge
   p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == MASK_BASE) |=> (mask_q[BANK_W-1:0] == $past(bus_wdata)));

   // R4: output low exactly when an unmasked status bit is set
   p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~mask_q) != '0) == !irq_n_o);

   // R7: status offset writes leave the masks untouched
   p_stat_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && (bus_addr == STAT_BASE || bus_addr == STAT_BASE + 16'd2))
      |=> $stable(mask_q));

   // R8: read data only moves after a read strobe
   p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

   // R9: a full mask keeps the line idle
   p_full_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> irq_n_o);
endmodule

bind irq_collector irqc_chk #(
   .NUM_SRC    (NUM_SRC),
   .BANK_W     (BANK_W),
   .ADDR_W     (ADDR_W),
   .SYNC_STAGES(SYNC_STAGES),
   .STAT_BASE  (STAT_BASE),
   .MASK_BASE  (MASK_BASE),
   .SRC_ACT_LOW(SRC_ACT_LOW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_i    (src_i),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .irq_n_o  (irq_n_o),
   .stat_q   (stat_q),
   .mask_q   (mask_q)
);

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] SRC_IDLE = 32'h0000_8000;

   logic        clk;
   logic        rst_n;
   logic [31:0] src_i;
   logic        bus_sel;
   logic        bus_wr;
   logic [15:0] bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic        irq_n_o;

   int n_checks = 0;
   int n_errors = 0;

   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen;
   bit          done = 0;

   irq_collector u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n_o(irq_n_o)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   // Monitor: compares registered read data against queued expectations
   always @(posedge clk) rd_seen <= rst_n && bus_sel && !bus_wr;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            check("scoreboard underflow", 32'd1, 32'd0);
         end else begin
            check(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
         end
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, input logic [15:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      check("watchdog expired", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; src_i = SRC_IDLE;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      cyc(3);
      check("R1 irq idle in reset", 32'(irq_n_o), 32'd1);
      check("R1 rdata zero in reset", 32'(bus_rdata), 32'd0);
      rst_n = 1'b1;
      cyc(3);
      bus_read(16'h0030, 16'hFFFF, "R1 mask lo reset");
      bus_read(16'h0032, 16'hFFFF, "R1 mask hi reset");
      bus_read(16'h0020, 16'h0000, "R2 status lo idle");

      // sources 3 and 20 pending, all masked
      src_i = 32'h0010_8008;
      cyc(3);
      check("R4 masked sources keep line high", 32'(irq_n_o), 32'd1);
      bus_read(16'h0020, 16'h0008, "R2 status lo bit3");
      bus_read(16'h0022, 16'h0010, "R2 status hi bit4 (source 20)");

      bus_write(16'h0030, 16'hFFF7);
      check("R4 unmask source 3 asserts line", 32'(irq_n_o), 32'd0);
      bus_read(16'h0030, 16'hFFF7, "R3 mask lo readback");
      bus_write(16'h0030, 16'hFFFF);
      check("R4 remask source 3 releases line", 32'(irq_n_o), 32'd1);
      bus_write(16'h0032, 16'hFFEF);
      check("R4 unmask source 20 asserts line", 32'(irq_n_o), 32'd0);
      bus_read(16'h0032, 16'hFFEF, "R3 mask hi readback");
      cyc(10);
      bus_read(16'h0022, 16'h0010, "R5 status held while source held");

      // release source 20: line follows two edges later
      src_i = 32'h0000_8008;
      cyc(1);
      check("R5 line still low one edge after release", 32'(irq_n_o), 32'd0);
      cyc(1);
      check("R5 line high two edges after release", 32'(irq_n_o), 32'd1);
      bus_read(16'h0022, 16'h0000, "R5 status hi cleared");

      // active-low source 15
      src_i = 32'h0000_0000;
      cyc(3);
      bus_read(16'h0020, 16'h8000, "R6 low input sets status bit15");
      bus_write(16'h0030, 16'h7FFF);
      check("R6 unmasked source 15 asserts line", 32'(irq_n_o), 32'd0);
      src_i = SRC_IDLE;
      cyc(3);
      check("R6 high input releases line", 32'(irq_n_o), 32'd1);
      bus_read(16'h0020, 16'h0000, "R6 high input clears status bit15");

      // status read-only and undecoded offsets
      bus_write(16'h0020, 16'hFFFF);
      bus_write(16'h0022, 16'h1234);
      bus_read(16'h0020, 16'h0000, "R7 status lo unchanged by write");
      bus_read(16'h0022, 16'h0000, "R7 status hi unchanged by write");
      bus_read(16'h0030, 16'h7FFF, "R7 mask lo untouched by status write");
      bus_read(16'h0032, 16'hFFEF, "R7 mask hi untouched by status write");
      bus_read(16'h0040, 16'h0000, "R7 undecoded offset reads zero");
      bus_read(16'h0031, 16'h0000, "R7 odd offset reads zero");

      // all sources pending
      src_i = 32'hFFFF_7FFF;
      cyc(3);
      bus_read(16'h0020, 16'hFFFF, "R2 all status lo set");
      bus_read(16'h0022, 16'hFFFF, "R2 all status hi set");
      bus_write(16'h0030, 16'h0000);
      bus_write(16'h0032, 16'h0000);
      check("R4 all unmasked asserts line", 32'(irq_n_o), 32'd0);
      bus_write(16'h0030, 16'hFFFF);
      check("R9 hi bank alone still asserts line", 32'(irq_n_o), 32'd0);
      bus_write(16'h0032, 16'hFFFF);
      check("R9 full mask releases line", 32'(irq_n_o), 32'd1);
      cyc(5);
      check("R9 full mask holds line high", 32'(irq_n_o), 32'd1);

      // registered read data holds between reads
      bus_read(16'h0032, 16'hFFFF, "R8 read value");
      bus_write(16'h0030, 16'h1111);
      cyc(3);
      check("R8 rdata held after write and idle", 32'(bus_rdata), 32'h0000_FFFF);
      bus_read(16'h0030, 16'h1111, "R8 next read updates");
      cyc(2);
      finish_run();
   end
endmodule